// File: doc/BRIEF.md
# External Data Memory Access Controller

This block carries out the data-space load and store operations of a byte-wide microcontroller core that addresses data through a 24-bit pointer. The core loads or increments the pointer and requests an access with a read/write flag and a write byte. The controller then reports busy, pulses done, and returns the read byte. Each access goes to one of two places. An on-chip 2 KB RAM port serves the bottom of the space, and a multiplexed external bus covers the whole 16 MB range.

The internal RAM is used only when the internal-RAM enable input is set and the pointer lies in the lowest 2 KB. When the enable is clear, every address goes to the external bus. An internal access leaves the external pins completely idle, so the core can use them as ordinary I/O.

An external access has a fixed phase order:
- a latch phase puts the low address byte on the shared address/data lines and the page byte on the upper lines;
- a strobe phase follows, and it can be stretched by a 3-bit wait-state count;
- a closing cycle comes last.

Every access takes 4 + N cycles. N is the wait count sampled when the request is accepted.

Top module: `xmem_access_ctrl`

## Requirements
- R1: After reset, busy, done, ale, ad_oe and ram_en are 0, rd_n and wr_n are 1, and dptr is 000000h.
- R2: ptr_load writes ptr_val into dptr. ptr_inc adds 1 modulo 2^24, so a carry out of the high byte (bits 15:8) reaches the page byte (bits 23:16). When both are high in the same cycle, ptr_load wins.
- R3: With cfg_int_en = 1, an address in 000000h–0007FFh goes to internal RAM, and any higher address goes to the external bus.
- R4: With cfg_int_en = 0, every address goes to the external bus, including the lowest 2 KB.
- R5: An internal access keeps the external pins quiet for its whole length: ale = 0, rd_n = wr_n = 1, ad_oe = 0. ram_en is high for exactly cycle 2, with ram_addr equal to address bits 10:0 and ram_we = 1 for writes.
- R6: With N wait states, an accepted access keeps busy high for 4 + N cycles, counting from the cycle after the accepting edge. done is high only in the last of those cycles, for both internal and external accesses.
- R7: External cycle 1 has ale = 1, ad_out = address bits 7:0 and ah_out = bits 23:16. In cycles 2 to 3 + N, ah_out = bits 15:8 and the read or write strobe (active low) is asserted. In cycle 4 + N both strobes are high.
- R8: During an external write, ad_oe = 1 and ad_out = the write byte for every cycle that wr_n is low. During an external read, ad_oe = 0 while rd_n is low.
- R9: A read returns on rdata, valid in the done cycle, the byte present at the end of cycle 3 + N. For an external read this is ad_in. For an internal read it is ram_rdata.
- R10: cfg_wait is sampled only at acceptance. Changing it during an access does not change that access's length.
- R11: A request is accepted only while busy is 0. A req_start raised during an access is ignored, so no second access follows. A ptr_inc in the accepting cycle does not change that access's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_int_en | input | 1 | Enables routing of the lowest 2 KB to internal RAM |
| cfg_wait | input | 3 | Wait-state count N |
| ptr_load | input | 1 | Load pointer from ptr_val |
| ptr_val | input | 24 | Pointer load value |
| ptr_inc | input | 1 | Increment pointer |
| dptr | output | 24 | Current pointer value |
| req_start | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte |
| ram_en | output | 1 | Internal RAM enable |
| ram_we | output | 1 | Internal RAM write enable |
| ram_addr | output | 11 | Internal RAM address |
| ram_wdata | output | 8 | Internal RAM write byte |
| ram_rdata | input | 8 | Internal RAM read byte (registered RAM output) |
| ad_out | output | 8 | Multiplexed low address / data out |
| ad_oe | output | 1 | Output enable of ad_out |
| ad_in | input | 8 | Multiplexed data in |
| ah_out | output | 8 | Page byte in cycle 1, high address byte afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | External read strobe, active low |
| wr_n | output | 1 | External write strobe, active low |

## Verification
Two functions can fall in the same edge: accepting a request and updating the pointer. The bench raises ptr_inc together with req_start on a pointer of 0007FFh with internal routing enabled. The access must still take the internal path with the old address and return that RAM byte, and dptr must then read 000800h. The same timing question is asked of a load and an increment that arrive together, where the load must win. Finally, a second req_start and a change of cfg_wait arrive inside every access of the sweep, and each access must keep its original length and phase pattern.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LATCH,
    ST_STRB,
    ST_LAST
  } xm_state_t;
endpackage

// File: rtl/xmem_route.sv
module xmem_route #(
  parameter int AW     = 24,
  parameter int RAM_AW = 11
) (
  input  logic                 int_en,
  input  logic [AW-RAM_AW-1:0] addr_hi,
  output logic                 is_ext
);
  // internal only when enabled and every bit above the RAM window is zero
  always_comb is_ext = !(int_en && (addr_hi == '0));
endmodule

// File: rtl/xmem_dptr.sv
module xmem_dptr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 8,
  parameter int RAM_AW = 11,
  parameter int WS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_ext,
  input  logic [WS_W-1:0]   wait_n,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in,
  output logic [DW-1:0]     ah_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int WCW = WS_W + 1;

  xm_state_t          st, nxt;
  logic [WCW-1:0]     wcnt;
  logic [AW-1:0]      a_q, a_n;
  logic [DW-1:0]      wd_q, wd_n;
  logic               we_q, we_n, ext_q, ext_n;
  logic               accept, strobe_n;

  assign accept = req_start && (st == ST_IDLE);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (accept) nxt = ST_LATCH;
      ST_LATCH: nxt = ST_STRB;
      ST_STRB:  if (wcnt == '0) nxt = ST_LAST;
      ST_LAST:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  // values that the next cycle's registered outputs are built from
  always_comb begin
    a_n      = accept ? req_addr  : a_q;
    wd_n     = accept ? req_wdata : wd_q;
    we_n     = accept ? req_we    : we_q;
    ext_n    = accept ? req_ext   : ext_q;
    strobe_n = (nxt == ST_STRB) && ext_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      wcnt  <= '0;
      a_q   <= '0;
      wd_q  <= '0;
      we_q  <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      st <= nxt;
      if (accept) begin
        a_q   <= req_addr;
        wd_q  <= req_wdata;
        we_q  <= req_we;
        ext_q <= req_ext;
        wcnt  <= WCW'(wait_n) + WCW'(1);
      end else if (st == ST_STRB && wcnt != '0) begin
        wcnt <= wcnt - WCW'(1);
      end
    end
  end

  // registered pin and handshake outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      ah_out <= '0;
      ram_en <= 1'b0;
      ram_we <= 1'b0;
    end else begin
      busy   <= (nxt != ST_IDLE);
      done   <= (nxt == ST_LAST);
      ale    <= (nxt == ST_LATCH) && ext_n;
      rd_n   <= !(strobe_n && !we_n);
      wr_n   <= !(strobe_n && we_n);
      ad_oe  <= ext_n && ((nxt == ST_LATCH) || (nxt == ST_STRB && we_n));
      if (ext_n && nxt == ST_LATCH)      ad_out <= a_n[DW-1:0];
      else if (strobe_n && we_n)         ad_out <= wd_n;
      else                               ad_out <= '0;
      if (!ext_n || nxt == ST_IDLE)      ah_out <= '0;
      else if (nxt == ST_LATCH)          ah_out <= a_n[AW-1:AW-DW];
      else                               ah_out <= a_n[2*DW-1:DW];
      ram_en <= (st == ST_LATCH) && !ext_q;
      ram_we <= (st == ST_LATCH) && !ext_q && we_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_addr  <= a_n[RAM_AW-1:0];
      ram_wdata <= wd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (st == ST_STRB && wcnt == '0 && !we_q)
      rdata <= ext_q ? ad_in : ram_rdata;
  end
endmodule

// File: rtl/xmem_access_ctrl.sv
module xmem_access_ctrl #(
  parameter int AW     = 24,
  parameter int DW     = 8,
  parameter int RAM_AW = 11,
  parameter int WS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_int_en,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_val,
  input  logic              ptr_inc,
  output logic [AW-1:0]     dptr,
  input  logic              req_start,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in,
  output logic [DW-1:0]     ah_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  logic route_ext;

  xmem_dptr #(.AW(AW)) u_dptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .inc(ptr_inc), .ptr(dptr)
  );

  xmem_route #(.AW(AW), .RAM_AW(RAM_AW)) u_route (
    .int_en(cfg_int_en), .addr_hi(dptr[AW-1:RAM_AW]), .is_ext(route_ext)
  );

  xmem_seq #(.AW(AW), .DW(DW), .RAM_AW(RAM_AW), .WS_W(WS_W)) u_seq (
    .clk(clk), .rst(rst),
    .req_start(req_start), .req_we(req_we), .req_wdata(req_wdata),
    .req_addr(dptr), .req_ext(route_ext), .wait_n(cfg_wait),
    .busy(busy), .done(done), .rdata(rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ah_out(ah_out),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );
endmodule

// File: rtl/xmem_access_ctrl_chk.sv
module xmem_access_ctrl_chk #(
  parameter int AW     = 24,
  parameter int DW     = 8,
  parameter int RAM_AW = 11,
  parameter int WS_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_int_en,
  input logic [WS_W-1:0]   cfg_wait,
  input logic              ptr_load,
  input logic [AW-1:0]     ptr_val,
  input logic              ptr_inc,
  input logic [AW-1:0]     dptr,
  input logic              req_start,
  input logic              req_we,
  input logic [DW-1:0]     req_wdata,
  input logic              busy,
  input logic              done,
  input logic [DW-1:0]     rdata,
  input logic              ram_en,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr,
  input logic [DW-1:0]     ram_wdata,
  input logic [DW-1:0]     ram_rdata,
  input logic [DW-1:0]     ad_out,
  input logic              ad_oe,
  input logic [DW-1:0]     ad_in,
  input logic [DW-1:0]     ah_out,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n
);
  localparam int CW = WS_W + 3;
  logic [CW-1:0]   cyc;
  logic [WS_W-1:0] n_c;
  logic [DW-1:0]   wd_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      n_c  <= '0;
      wd_c <= '0;
    end else if (req_start && !busy) begin
      cyc  <= CW'(1);
      n_c  <= cfg_wait;
      wd_c <= req_wdata;
    end else if (busy) begin
      cyc <= cyc + CW'(1);
    end
  end

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ale && rd_n && wr_n && !ad_oe && !ram_en && !done));

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ptr_inc) && !$past(ptr_load)) |-> dptr == AW'($past(dptr) + AW'(1)));

  p_int_no_pins_r5: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> (!ale && rd_n && wr_n && !ad_oe));

  p_len_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == CW'(n_c) + CW'(4)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latch_then_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (!rd_n || !wr_n));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_wdata_on_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (ad_oe && ad_out == wd_c));

  p_read_hiz_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
endmodule

bind xmem_access_ctrl xmem_access_ctrl_chk #(
  .AW(AW), .DW(DW), .RAM_AW(RAM_AW), .WS_W(WS_W)
) u_chk (.*);

// File: tb/xmem_access_ctrl_bench.sv
module xmem_access_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_int_en;
  logic [2:0]  cfg_wait;
  logic        ptr_load;
  logic [23:0] ptr_val;
  logic        ptr_inc;
  logic [23:0] dptr;
  logic        req_start, req_we;
  logic [7:0]  req_wdata;
  logic        busy, done;
  logic [7:0]  rdata;
  logic        ram_en, ram_we;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [7:0]  ad_out, ad_in, ah_out;
  logic        ad_oe, ale, rd_n, wr_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [23:0] cur_addr;
  logic [7:0]  mem [2048];

  always #10 clk = ~clk;

  xmem_access_ctrl u_xmem_access_ctrl (.*);

  function automatic logic [7:0] ext_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  always_comb ad_in = !rd_n ? ext_val(cur_addr) : 8'h00;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic set_ptr(input logic [23:0] a);
    @(negedge clk);
    ptr_load = 1'b1; ptr_val = a;
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  // one access; expected pins computed per cycle from R3..R11
  task automatic run_access(input logic [23:0] a, input logic ie, input logic [2:0] n,
                            input logic we, input logic [7:0] wd, input logic with_inc);
    logic ext, strb;
    logic [7:0] exp_rd;
    logic [7:0] got_v, exp_v;
    int last;
    set_ptr(a);
    cur_addr   = a;
    cfg_int_en = ie;
    cfg_wait   = n;
    ext    = !(ie && a[23:11] == 13'd0);
    exp_rd = ext ? ext_val(a) : mem[a[10:0]];
    last   = 4 + int'(n);
    req_start = 1'b1; req_we = we; req_wdata = wd; ptr_inc = with_inc;
    @(negedge clk);
    req_start = 1'b0; ptr_inc = 1'b0;
    cfg_wait  = ~n;                       // R10: must not stretch this access
    for (int c = 1; c <= last; c++) begin
      if (c == 2) begin req_start = 1'b1; req_we = ~we; end   // R11: ignored
      if (c == 3) req_start = 1'b0;
      strb  = ext && c >= 2 && c <= 3 + int'(n);
      got_v = {busy, done, ale, rd_n, wr_n, ad_oe, ram_en, ram_we};
      exp_v = {1'b1, c == last, ext && c == 1, !(strb && !we), !(strb && we),
               ext && (c == 1 || (strb && we)), !ext && c == 2, !ext && c == 2 && we};
      chk(got_v == exp_v, $sformatf("R3 R4 R5 R6 R7 a=%h ie=%0b n=%0d we=%0b cyc %0d got %b exp %b",
                                    a, ie, n, we, c, got_v, exp_v));
      if (ext && c == 1)
        chk(ad_out == a[7:0] && ah_out == a[23:16],
            $sformatf("R7 latch a=%h got ad=%h ah=%h exp %h %h", a, ad_out, ah_out, a[7:0], a[23:16]));
      if (ext && c == 2)
        chk(ah_out == a[15:8], $sformatf("R7 high byte a=%h got %h exp %h", a, ah_out, a[15:8]));
      if (strb && we)
        chk(ad_out == wd, $sformatf("R8 write data cyc %0d got %h exp %h", c, ad_out, wd));
      if (!ext && c == 2)
        chk(ram_addr == a[10:0], $sformatf("R5 ram_addr got %h exp %h", ram_addr, a[10:0]));
      if (c == last && !we)
        chk(rdata == exp_rd, $sformatf("R9 read a=%h ext=%0b got %h exp %h", a, ext, rdata, exp_rd));
      @(negedge clk);
    end
    chk(!busy && !done, $sformatf("R11 no second access got busy=%0b done=%0b exp 0 0", busy, done));
    if (!ext && we)
      chk(mem[a[10:0]] == wd, $sformatf("R5 ram write got %h exp %h", mem[a[10:0]], wd));
    chk(dptr == a + 24'(with_inc), $sformatf("R11 pointer after access got %h exp %h", dptr, a + 24'(with_inc)));
  endtask

  initial begin
    logic [23:0] addrs [5];
    addrs[0] = 24'h000000; addrs[1] = 24'h0003A5; addrs[2] = 24'h0007FF;
    addrs[3] = 24'h000800; addrs[4] = 24'hC3F0A7;
    for (int i = 0; i < 2048; i++) mem[i] = 8'(i) ^ 8'hC3;
    rst = 1'b1; cfg_int_en = 1'b0; cfg_wait = 3'd0; ptr_load = 1'b0; ptr_val = '0;
    ptr_inc = 1'b0; req_start = 1'b0; req_we = 1'b0; req_wdata = '0;
    cur_addr = '0; ram_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, ale, rd_n, wr_n, ad_oe, ram_en} == 7'b0001100 && dptr == 24'd0,
        $sformatf("R1 reset got %b dptr=%h exp 0001100 000000",
                  {busy, done, ale, rd_n, wr_n, ad_oe, ram_en}, dptr));

    // R2 pointer carry, wrap and load priority
    set_ptr(24'h00FFFF);
    ptr_inc = 1'b1; @(negedge clk); ptr_inc = 1'b0;
    chk(dptr == 24'h010000, $sformatf("R2 carry into page got %h exp 010000", dptr));
    set_ptr(24'hFFFFFF);
    ptr_inc = 1'b1; @(negedge clk); ptr_inc = 1'b0;
    chk(dptr == 24'h000000, $sformatf("R2 wrap got %h exp 000000", dptr));
    ptr_load = 1'b1; ptr_val = 24'h123456; ptr_inc = 1'b1;
    @(negedge clk);
    ptr_load = 1'b0; ptr_inc = 1'b0;
    chk(dptr == 24'h123456, $sformatf("R2 load wins got %h exp 123456", dptr));

    // sweep of routing, wait states and direction
    for (int ie = 0; ie < 2; ie++)
      for (int n = 0; n < 8; n++)
        for (int ai = 0; ai < 5; ai++)
          for (int w = 0; w < 2; w++)
            run_access(addrs[ai], 1'(ie), 3'(n), 1'(w), 8'(ai * 37 + n * 11 + w), 1'b0);

    // R11: start and increment on the same edge use the old address
    run_access(24'h0007FF, 1'b1, 3'd0, 1'b0, 8'h00, 1'b1);
    run_access(24'h0007FF, 1'b1, 3'd2, 1'b1, 8'hE1, 1'b1);
    run_access(24'hFFFFFF, 1'b1, 3'd1, 1'b0, 8'h00, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule